// File: doc/BRIEF.md
# Multiported Register Value Cache

This block is a small fully associative store that keeps copies of physical register values close to the execution units. Each entry is tagged with a register number instead of a memory address. The larger main register file keeps the home copy of every value. Several source-operand read ports each present a register number in the same cycle. Each port returns at once a hit flag and, on a hit, the stored value. Downstream arbitration uses the hit flags to decide which operands must be fetched from the main file.

Every execution result goes into the cache in a cache-write stage after execute, whether or not it is ever read. Several write ports deliver a register number and a value per cycle. A result whose register number is already cached overwrites that entry in place. A new register number takes the least recently used entry. The old contents of that entry are dropped, because the main file also receives every result. Reads and writes both refresh the recency order. Reads never fill the cache. The storage is split into a tag array and a data array, with a recency tracker beside them.

Top module: `rvc_top`

## Requirements
- R1: A read port with its enable high reports a hit in the same cycle when a valid entry holds the presented register number, and it then outputs that entry's value. While no write occurs, a cached value stays readable and unchanged.
- R2: A synchronous active-high reset invalidates every entry, so all reads miss in the first cycle after reset.
- R3: Every write is allocated, so a read of that register number in any later cycle hits and returns the written value until the entry is evicted.
- R4: A write to a register number that is already cached replaces the value in the same entry and evicts nothing.
- R5: A read in the same cycle as a write to the same register number returns the contents from before that write (a miss if the number was not cached).
- R6: A write that misses evicts the entry that was least recently used.
- R7: A read hit makes its entry most recently used, so it is protected from the next eviction.
- R8: When several writes miss in one cycle, each takes a different victim, and the lower-numbered write port takes the older one. The entry written by the lower port is left older than the one written by the higher port.
- R9: An entry that a write hits in a cycle is never chosen as a victim by another write in that same cycle.
- R10: When two write ports carry the same register number in one cycle, one entry results, holding the value from the higher-numbered port.
- R11: A read miss does not fill the cache. A read port with its enable low reports a miss. A port that misses outputs all-zero data.
- R12: After a cycle, the entries written in it are newer than the entries only read in it, and the entries only read are newer than the entries untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | RD_PORTS | Per read port: lookup request |
| rd_reg | input | RD_PORTS x REG_W | Per read port: register number |
| rd_hit | output | RD_PORTS | Per read port: hit flag |
| rd_data | output | RD_PORTS x DATA_W | Per read port: cached value, zero on miss |
| wr_en | input | WR_PORTS | Per write port: result valid |
| wr_reg | input | WR_PORTS x REG_W | Per write port: destination register number |
| wr_data | input | WR_PORTS x DATA_W | Per write port: result value |

## Verification
The hardest cases to reach from the ports are the ones that depend on the hidden recency order. Examples are a write hit that lands on the oldest entry while another port misses in the same cycle, and the relative age of two victims filled in one cycle. The stimulus first brings the cache to a known full order by filling it with eight distinct registers in a fixed sequence. It then applies the corner-case cycle. After that it issues a counted run of single-port writes, so that which register disappears first shows the order the corner case left behind. The probing reads come only at the end of each test, so they do not disturb the order under test.

// File: rtl/rvc_pkg.sv
`timescale 1ns/1ps
package rvc_pkg;

    // Recency class of an entry for one cycle; a higher value means newer.
    typedef enum logic [1:0] {
        TOUCH_NONE  = 2'd0,
        TOUCH_READ  = 2'd1,
        TOUCH_WRITE = 2'd2
    } touch_e;

    localparam int DEF_ENTRIES  = 8;
    localparam int DEF_RD_PORTS = 4;
    localparam int DEF_WR_PORTS = 2;
    localparam int DEF_REG_W    = 7;
    localparam int DEF_DATA_W   = 64;

    // Width of an index into n items, at least one bit.
    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rvc_tag_array.sv
`timescale 1ns/1ps
module rvc_tag_array #(
    parameter int ENTRIES  = 8,
    parameter int REG_W    = 7,
    parameter int RD_PORTS = 4,
    parameter int WR_PORTS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [RD_PORTS-1:0][REG_W-1:0]       rd_reg,
    input  logic [WR_PORTS-1:0][REG_W-1:0]       wr_reg,
    input  logic [ENTRIES-1:0]                   ent_we,
    input  logic [ENTRIES-1:0][REG_W-1:0]        ent_tag,
    output logic [RD_PORTS-1:0][ENTRIES-1:0]     rd_match,
    output logic [WR_PORTS-1:0][ENTRIES-1:0]     wr_match
);

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][REG_W-1:0] tag_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[e] <= 1'b0;
            end else if (ent_we[e]) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (ent_we[e]) begin
                tag_q[e] <= ent_tag[e];
            end
        end

        for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
            assign rd_match[p][e] = valid_q[e] && (tag_q[e] == rd_reg[p]);
        end

        for (genvar w = 0; w < WR_PORTS; w++) begin : g_wr
            assign wr_match[w][e] = valid_q[e] && (tag_q[e] == wr_reg[w]);
        end
    end

endmodule

// File: rtl/rvc_data_array.sv
`timescale 1ns/1ps
module rvc_data_array #(
    parameter int ENTRIES  = 8,
    parameter int DATA_W   = 64,
    parameter int RD_PORTS = 4
) (
    input  logic                                 clk,
    input  logic [ENTRIES-1:0]                   ent_we,
    input  logic [ENTRIES-1:0][DATA_W-1:0]       ent_data,
    input  logic [RD_PORTS-1:0][ENTRIES-1:0]     rd_sel,
    output logic [RD_PORTS-1:0][DATA_W-1:0]      rd_data
);

    logic [ENTRIES-1:0][DATA_W-1:0] data_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (ent_we[e]) begin
                data_q[e] <= ent_data[e];
            end
        end
    end

    // One-hot select per port: AND-OR read mux, zero when nothing selected.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            for (int e = 0; e < ENTRIES; e++) begin
                if (rd_sel[p][e]) begin
                    rd_data[p] = rd_data[p] | data_q[e];
                end
            end
        end
    end

endmodule

// File: rtl/rvc_lru.sv
`timescale 1ns/1ps
module rvc_lru
    import rvc_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int WR_PORTS = 2,
    localparam int RANK_W  = idx_w(ENTRIES),
    localparam int WP_W    = idx_w(WR_PORTS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  touch_e [ENTRIES-1:0]              touch,
    input  logic   [ENTRIES-1:0][WP_W-1:0]    wport,
    output logic   [ENTRIES-1:0][RANK_W-1:0]  rank
);

    localparam int CNT_W = RANK_W + 1;

    // rank 0 is the least recently used entry, ENTRIES-1 the newest
    logic [ENTRIES-1:0][RANK_W-1:0] rank_q;
    logic [ENTRIES-1:0][RANK_W-1:0] rank_d;

    // New rank = number of entries whose (class, order) key is smaller.
    // Order inside a class: old rank for untouched and read-only entries,
    // write port number for written entries.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            logic [CNT_W-1:0] cnt;
            cnt = '0;
            for (int f = 0; f < ENTRIES; f++) begin
                if (f != e) begin
                    if (touch[f] < touch[e]) begin
                        cnt = cnt + CNT_W'(1);
                    end else if (touch[f] == touch[e]) begin
                        if (touch[e] == TOUCH_WRITE) begin
                            if (wport[f] < wport[e]) cnt = cnt + CNT_W'(1);
                        end else begin
                            if (rank_q[f] < rank_q[e]) cnt = cnt + CNT_W'(1);
                        end
                    end
                end
            end
            rank_d[e] = cnt[RANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                rank_q[e] <= RANK_W'(e);
            end
        end else begin
            rank_q <= rank_d;
        end
    end

    assign rank = rank_q;

endmodule

// File: rtl/rvc_top.sv
`timescale 1ns/1ps
module rvc_top
    import rvc_pkg::*;
#(
    parameter int ENTRIES  = DEF_ENTRIES,
    parameter int RD_PORTS = DEF_RD_PORTS,
    parameter int WR_PORTS = DEF_WR_PORTS,
    parameter int REG_W    = DEF_REG_W,
    parameter int DATA_W   = DEF_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [RD_PORTS-1:0]              rd_en,
    input  logic [RD_PORTS-1:0][REG_W-1:0]   rd_reg,
    output logic [RD_PORTS-1:0]              rd_hit,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data,
    input  logic [WR_PORTS-1:0]              wr_en,
    input  logic [WR_PORTS-1:0][REG_W-1:0]   wr_reg,
    input  logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data
);

    localparam int RANK_W = idx_w(ENTRIES);
    localparam int WP_W   = idx_w(WR_PORTS);
    localparam int CNT_W  = RANK_W + 1;

    logic [RD_PORTS-1:0][ENTRIES-1:0] rd_match;
    logic [RD_PORTS-1:0][ENTRIES-1:0] rd_sel;
    logic [WR_PORTS-1:0][ENTRIES-1:0] wr_match;
    logic [ENTRIES-1:0][RANK_W-1:0]   rank;

    logic [WR_PORTS-1:0]              wr_eff;
    logic [WR_PORTS-1:0]              wr_miss;
    logic [WR_PORTS-1:0][CNT_W-1:0]   miss_idx;
    logic [ENTRIES-1:0]               hit_mask;
    logic [ENTRIES-1:0][CNT_W-1:0]    elig_rank;

    logic [ENTRIES-1:0]               ent_we;
    logic [ENTRIES-1:0][WP_W-1:0]     ent_port;
    logic [ENTRIES-1:0][REG_W-1:0]    ent_tag;
    logic [ENTRIES-1:0][DATA_W-1:0]   ent_data;
    touch_e [ENTRIES-1:0]             touch;

    rvc_tag_array #(
        .ENTRIES (ENTRIES),
        .REG_W   (REG_W),
        .RD_PORTS(RD_PORTS),
        .WR_PORTS(WR_PORTS)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .rd_reg  (rd_reg),
        .wr_reg  (wr_reg),
        .ent_we  (ent_we),
        .ent_tag (ent_tag),
        .rd_match(rd_match),
        .wr_match(wr_match)
    );

    rvc_data_array #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .RD_PORTS(RD_PORTS)
    ) u_data (
        .clk     (clk),
        .ent_we  (ent_we),
        .ent_data(ent_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    rvc_lru #(
        .ENTRIES (ENTRIES),
        .WR_PORTS(WR_PORTS)
    ) u_lru (
        .clk  (clk),
        .rst  (rst),
        .touch(touch),
        .wport(ent_port),
        .rank (rank)
    );

    // Read side: lookups see the state before this cycle's writes.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_sel[p] = rd_match[p] & {ENTRIES{rd_en[p]}};
        assign rd_hit[p] = |rd_sel[p];
    end

    // A write is dropped if a higher port writes the same register.
    always_comb begin
        for (int w = 0; w < WR_PORTS; w++) begin
            wr_eff[w] = wr_en[w];
            for (int v = 0; v < WR_PORTS; v++) begin
                if (v > w && wr_en[v] && wr_reg[v] == wr_reg[w]) begin
                    wr_eff[w] = 1'b0;
                end
            end
            wr_miss[w] = wr_eff[w] && !(|wr_match[w]);
        end
    end

    // Entries hit by a write this cycle are not eligible victims.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            hit_mask[e] = 1'b0;
            for (int w = 0; w < WR_PORTS; w++) begin
                if (wr_eff[w] && wr_match[w][e]) hit_mask[e] = 1'b1;
            end
        end
    end

    // Age position of each entry among the eligible ones (0 = oldest).
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            elig_rank[e] = '0;
            for (int f = 0; f < ENTRIES; f++) begin
                if (!hit_mask[f] && rank[f] < rank[e]) begin
                    elig_rank[e] = elig_rank[e] + CNT_W'(1);
                end
            end
        end
    end

    // k-th missing write port (in port order) takes the k-th oldest victim.
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int w = 0; w < WR_PORTS; w++) begin
            miss_idx[w] = run;
            if (wr_miss[w]) run = run + CNT_W'(1);
        end
    end

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            ent_we[e]   = 1'b0;
            ent_port[e] = '0;
            for (int w = 0; w < WR_PORTS; w++) begin
                if ((wr_eff[w] && wr_match[w][e]) ||
                    (wr_miss[w] && !hit_mask[e] && elig_rank[e] == miss_idx[w])) begin
                    ent_we[e]   = 1'b1;
                    ent_port[e] = WP_W'(w);
                end
            end
            ent_tag[e]  = wr_reg[ent_port[e]];
            ent_data[e] = wr_data[ent_port[e]];
        end
    end

    // Recency class per entry for this cycle.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            logic rd_any;
            rd_any = 1'b0;
            for (int p = 0; p < RD_PORTS; p++) begin
                if (rd_sel[p][e]) rd_any = 1'b1;
            end
            if (ent_we[e])   touch[e] = TOUCH_WRITE;
            else if (rd_any) touch[e] = TOUCH_READ;
            else             touch[e] = TOUCH_NONE;
        end
    end

endmodule

// File: rtl/rvc_checker.sv
`timescale 1ns/1ps
module rvc_checker #(
    parameter int ENTRIES  = 8,
    parameter int RD_PORTS = 4,
    parameter int WR_PORTS = 2,
    parameter int REG_W    = 7,
    parameter int DATA_W   = 64
) (
    input logic                             clk,
    input logic                             rst,
    input logic [RD_PORTS-1:0]              rd_en,
    input logic [RD_PORTS-1:0][REG_W-1:0]   rd_reg,
    input logic [RD_PORTS-1:0]              rd_hit,
    input logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data,
    input logic [WR_PORTS-1:0]              wr_en,
    input logic [WR_PORTS-1:0][REG_W-1:0]   wr_reg,
    input logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data
);

    localparam int TOPW = WR_PORTS - 1;

    logic [RD_PORTS-1:0] wr_same;

    always_comb begin
        for (int p = 0; p < RD_PORTS; p++) begin
            wr_same[p] = 1'b0;
            for (int w = 0; w < WR_PORTS; w++) begin
                if (wr_en[w] && wr_reg[w] == rd_reg[p]) wr_same[p] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
            !rd_hit[p] |-> rd_data[p] == '0); // R11

        AST_IDLE_PORT_MISS: assert property (@(posedge clk) disable iff (rst)
            !rd_en[p] |-> !rd_hit[p]); // R11

        AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !rd_hit[p]); // R2

        AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
            wr_en[TOPW] |=> ((rd_en[p] && rd_reg[p] == $past(wr_reg[TOPW]))
                             |-> (rd_hit[p] && rd_data[p] == $past(wr_data[TOPW])))); // R3

        AST_MISS_NO_FILL: assert property (@(posedge clk) disable iff (rst)
            (rd_en[p] && !rd_hit[p] && !wr_same[p])
            |=> ((rd_en[p] && rd_reg[p] == $past(rd_reg[p])) |-> !rd_hit[p])); // R11

        AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (rd_en[p] && rd_hit[p] && wr_en == '0)
            |=> ((rd_en[p] && rd_reg[p] == $past(rd_reg[p]))
                 |-> (rd_hit[p] && rd_data[p] == $past(rd_data[p])))); // R1
    end

endmodule

bind rvc_top rvc_checker #(
    .ENTRIES (ENTRIES),
    .RD_PORTS(RD_PORTS),
    .WR_PORTS(WR_PORTS),
    .REG_W   (REG_W),
    .DATA_W  (DATA_W)
) u_rvc_checker (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_reg (rd_reg),
    .rd_hit (rd_hit),
    .rd_data(rd_data),
    .wr_en  (wr_en),
    .wr_reg (wr_reg),
    .wr_data(wr_data)
);

// File: tb/test_rvc_top.sv
`timescale 1ns/1ps
module test_rvc_top;

    localparam int ENTRIES  = 8;
    localparam int RD_PORTS = 4;
    localparam int WR_PORTS = 2;
    localparam int REG_W    = 7;
    localparam int DATA_W   = 64;

    logic                             clk = 1'b0;
    logic                             rst = 1'b1;
    logic [RD_PORTS-1:0]              rd_en;
    logic [RD_PORTS-1:0][REG_W-1:0]   rd_reg;
    logic [RD_PORTS-1:0]              rd_hit;
    logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data;
    logic [WR_PORTS-1:0]              wr_en;
    logic [WR_PORTS-1:0][REG_W-1:0]   wr_reg;
    logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rvc_top #(
        .ENTRIES (ENTRIES),
        .RD_PORTS(RD_PORTS),
        .WR_PORTS(WR_PORTS),
        .REG_W   (REG_W),
        .DATA_W  (DATA_W)
    ) i_rvc_top (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .rd_reg (rd_reg),
        .rd_hit (rd_hit),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_reg (wr_reg),
        .wr_data(wr_data)
    );

    typedef struct packed {
        logic       w0e;
        logic [6:0] w0r;
        logic [7:0] w0v;
        logic       w1e;
        logic [6:0] w1r;
        logic [7:0] w1v;
        logic [3:0] re;
        logic [6:0] r0;
        logic [6:0] r1;
        logic [6:0] r2;
        logic [6:0] r3;
        logic [3:0] eh;   // expected hit, bit p = read port p
        logic [7:0] ev0;  // expected version on read port 0 when it hits
    } vec_t;

    // Rows run in sequence from an empty cache.
    localparam vec_t TBL [0:9] = '{
        '{1'b1,7'd10,8'd1, 1'b1,7'd11,8'd1, 4'hF,7'd10,7'd11,7'd12,7'd13, 4'b0000,8'd0},
        '{1'b1,7'd12,8'd1, 1'b1,7'd13,8'd1, 4'hF,7'd10,7'd11,7'd12,7'd13, 4'b0011,8'd1},
        '{1'b1,7'd10,8'd2, 1'b0,7'd0, 8'd0, 4'hF,7'd10,7'd12,7'd13,7'd20, 4'b0111,8'd1},
        '{1'b0,7'd0, 8'd0, 1'b0,7'd0, 8'd0, 4'hF,7'd10,7'd11,7'd20,7'd21, 4'b0011,8'd2},
        '{1'b1,7'd20,8'd1, 1'b1,7'd21,8'd1, 4'h0,7'd0, 7'd0, 7'd0, 7'd0,  4'b0000,8'd0},
        '{1'b1,7'd22,8'd1, 1'b1,7'd23,8'd1, 4'h0,7'd0, 7'd0, 7'd0, 7'd0,  4'b0000,8'd0},
        '{1'b1,7'd30,8'd1, 1'b1,7'd31,8'd1, 4'hF,7'd12,7'd13,7'd10,7'd11, 4'b1111,8'd1},
        '{1'b0,7'd0, 8'd0, 1'b0,7'd0, 8'd0, 4'hF,7'd12,7'd13,7'd30,7'd31, 4'b1100,8'd0},
        '{1'b0,7'd0, 8'd0, 1'b1,7'd40,8'd1, 4'hF,7'd20,7'd10,7'd11,7'd40, 4'b0111,8'd1},
        '{1'b0,7'd0, 8'd0, 1'b0,7'd0, 8'd0, 4'hF,7'd20,7'd40,7'd21,7'd50, 4'b0110,8'd0}
    };

    function automatic logic [DATA_W-1:0] mk(int r, int v);
        return (DATA_W'(r) << 16) | DATA_W'(v);
    endfunction

    task automatic idle();
        rd_en   = '0;
        rd_reg  = '0;
        wr_en   = '0;
        wr_reg  = '0;
        wr_data = '0;
    endtask

    task automatic setw(int w, int r, int v);
        wr_en[w]   = 1'b1;
        wr_reg[w]  = REG_W'(r);
        wr_data[w] = mk(r, v);
    endtask

    task automatic setr(int p, int r);
        rd_en[p]  = 1'b1;
        rd_reg[p] = REG_W'(r);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // Compare read port p; data is compared when chk_d is set.
    task automatic check(string req, int p, logic exp_hit, logic chk_d, logic [DATA_W-1:0] exp_d);
        #1;
        n_chk++;
        if (rd_hit[p] !== exp_hit || (chk_d && rd_data[p] !== exp_d)) begin
            n_fail++;
            $display("FAIL %s port %0d: hit=%0b data=%h, expected hit=%0b data=%h",
                     req, p, rd_hit[p], rd_data[p], exp_hit, exp_d);
        end
    endtask

    // Read register r on port p and compare against a hit with version v or a miss.
    task automatic look(string req, int p, int r, logic exp_hit, int v);
        setr(p, r);
        check(req, p, exp_hit, 1'b1, exp_hit ? mk(r, v) : '0);
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // Fill with base..base+7; oldest to newest in that order.
    task automatic fill(int base);
        do_reset();
        for (int i = 0; i < 4; i++) begin
            setw(0, base + 2 * i, 1);
            setw(1, base + 2 * i + 1, 1);
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        @(negedge clk);
        do_reset();

        // R2: empty after reset
        for (int p = 0; p < RD_PORTS; p++) look("R2 reset empty", p, 10 + p, 1'b0, 0);
        tick();

        // Table walk: R1 R3 R5 R6 R7 R8 R11
        for (int i = 0; i < 10; i++) begin
            vec_t v;
            v = TBL[i];
            if (v.w0e) setw(0, int'(v.w0r), int'(v.w0v));
            if (v.w1e) setw(1, int'(v.w1r), int'(v.w1v));
            if (v.re[0]) setr(0, int'(v.r0));
            if (v.re[1]) setr(1, int'(v.r1));
            if (v.re[2]) setr(2, int'(v.r2));
            if (v.re[3]) setr(3, int'(v.r3));
            for (int p = 0; p < RD_PORTS; p++) begin
                if (p == 0 && v.eh[0])
                    check("R1 R3 R5 table", 0, 1'b1, 1'b1, mk(int'(v.r0), int'(v.ev0)));
                else if (v.eh[p])
                    check("R1 R6 R7 table", p, 1'b1, 1'b0, '0);
                else
                    check("R11 R6 table miss", p, 1'b0, 1'b1, '0);
            end
            tick();
        end

        // R3: eight writes all stay resident; R2: reset empties them
        fill(1);
        for (int p = 0; p < 4; p++) look("R3 fill", p, 1 + p, 1'b1, 1);
        tick();
        for (int p = 0; p < 4; p++) look("R3 fill", p, 5 + p, 1'b1, 1);
        tick();
        do_reset();
        for (int p = 0; p < 4; p++) look("R2 reset clears", p, 1 + p, 1'b0, 0);
        tick();

        // R7: a read protects the oldest entry; R6: next oldest goes
        fill(1);
        setr(0, 1);
        tick();
        setw(0, 60, 1);
        tick();
        look("R7 read refresh", 0, 1, 1'b1, 1);
        look("R6 lru victim", 1, 2, 1'b0, 0);
        look("R3 new entry", 2, 60, 1'b1, 1);
        tick();

        // R8: dual miss, lower port gets the older victim and stays older
        fill(1);
        setw(0, 9, 1);
        setw(1, 10, 1);
        tick();
        for (int i = 0; i < 7; i++) begin
            setw(0, 11 + i, 1);
            tick();
        end
        look("R8 lower port older", 0, 9, 1'b0, 0);
        look("R8 higher port kept", 1, 10, 1'b1, 1);
        look("R8 distinct victims", 2, 1, 1'b0, 0);
        look("R8 distinct victims", 3, 2, 1'b0, 0);
        tick();

        // R9 and R4: write hit on the oldest entry while another port misses
        fill(1);
        setw(0, 99, 1);
        setw(1, 1, 5);
        tick();
        look("R4 in-place update", 0, 1, 1'b1, 5);
        look("R9 victim skips hit entry", 1, 2, 1'b0, 0);
        look("R9 miss allocated", 2, 99, 1'b1, 1);
        look("R4 no extra eviction", 3, 3, 1'b1, 1);
        tick();
        for (int p = 0; p < 4; p++) look("R4 no extra eviction", p, 5 + p, 1'b1, 1);
        tick();
        look("R4 no extra eviction", 0, 4, 1'b1, 1);
        tick();

        // R10: both ports write one register in one cycle
        fill(1);
        setw(0, 50, 3);
        setw(1, 50, 4);
        tick();
        look("R10 higher port value", 0, 50, 1'b1, 4);
        look("R10 single victim", 1, 1, 1'b0, 0);
        look("R10 single victim", 2, 2, 1'b1, 1);
        tick();

        // R12: a written entry ends newer than a read-only one in the same cycle
        fill(1);
        setr(0, 1);
        setw(0, 2, 2);
        tick();
        for (int i = 0; i < 7; i++) begin
            setw(0, 61 + i, 1);
            tick();
        end
        look("R12 read older than write", 0, 1, 1'b0, 0);
        look("R12 write newest", 1, 2, 1'b1, 2);
        tick();

        // R5: read and write of an uncached register in one cycle
        do_reset();
        setw(1, 70, 1);
        look("R5 same-cycle old contents", 0, 70, 1'b0, 0);
        tick();
        look("R3 visible next cycle", 0, 70, 1'b1, 1);
        tick();

        // R11: read misses never fill; a disabled port reports a miss
        setr(0, 77);
        check("R11 read miss", 0, 1'b0, 1'b1, '0);
        tick();
        look("R11 no fill", 0, 77, 1'b0, 0);
        rd_reg[1] = REG_W'(70);
        check("R11 disabled port", 1, 1'b0, 1'b1, '0);
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule